// File: doc/BRIEF.md
# Divided-Clock Phase-Frequency Detector

This block is the digital front end of an integer-N frequency synthesizer. It receives two edge strobes in the fast system clock domain. One marks each rising edge of a fixed crystal reference. The other marks each rising edge of the oscillator feedback. Each strobe stream goes through its own programmable divider. The two divided event streams drive a two-register phase-frequency detector, which produces the charge-pump drive signals. A pump-up request is raised when the divided reference arrives first. A pump-down request is raised when the divided feedback arrives first. Each request lasts as many system cycles as the two events are apart.

A third register, the overlap hold, is set whenever both detector registers are set at once. It stays set as long as either detector register is still set, and it keeps both pump outputs low during that time. If an event lands in the very cycle in which the pair is being cleared, it therefore cannot leak out as a short, false pump pulse. It is held back until the opposite event arrives and the pair clears together.

A typical setup uses a 10 MHz crystal divided by 100 or by 20 for a 100 kHz or 500 kHz comparison rate, with a feedback ratio such as 198 or 39. Each ratio is read from its port at the divider's terminal count, so a ratio can be reprogrammed while the loop is running.

Top module: `pfd_front`

## Requirements
- R1: Each divider emits one single-cycle event on the first strobe after reset, and then one event every `ratio` strobes. The event reaches the detector one cycle after the strobe.
- R2: A programmed ratio of 0 or 1 behaves as a ratio of 2.
- R3: A new ratio on a ratio port has no effect on the count in progress. It is loaded only when that divider's count reaches its terminal value.
- R4: When the divided reference leads, `pump_up` is high for exactly as many cycles as the lead and `pump_dn` stays low. This also holds when the reference runs at a higher divided frequency than the feedback.
- R5: When the divided feedback leads, `pump_dn` is high for exactly as many cycles as the lead and `pump_up` stays low.
- R6: When the two divided events occur in the same cycle, neither output asserts.
- R7: `pump_up` and `pump_dn` are never high in the same cycle.
- R8: The overlap hold is set by both detector registers being set, and it remains set while either of them is set. While it is set, both outputs stay low. An event that arrives in the clearing cycle sets its register again but is held off until the opposite event arrives.
- R9: Driving `rst_n` low clears both outputs at once, without waiting for a clock edge. It also restarts both dividers. Release of `rst_n` takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, fast compared with both strobe streams |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| ref_tick | input | 1 | One-cycle strobe per crystal reference edge |
| fb_tick | input | 1 | One-cycle strobe per feedback oscillator edge |
| ref_ratio | input | RATIO_W | Reference divide ratio |
| fb_ratio | input | RATIO_W | Feedback divide ratio |
| pump_up | output | 1 | Charge-pump raise request |
| pump_dn | output | 1 | Charge-pump lower request |

## Verification
The hardest condition to reach is an event that lands exactly in the cycle in which both detector registers are being cleared. Only then does the overlap hold do more than the plain clear does. The bench creates this condition by setting both ratios to 2. It sends reference strobes on three consecutive cycles and one feedback strobe on the middle cycle, so the second divided reference event lands on the clear. It then checks that the re-set register produces no pump pulse until two further feedback strobes release it. Coincident events and mid-count ratio changes are created by aligning strobe phases, and by rewriting a ratio port one cycle after a terminal count.

// File: rtl/pfd_front_pkg.sv
package pfd_front_pkg;

  // channel indices into the divider array
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;
  localparam int unsigned NUM_CH = 2;

  // detector register set
  typedef struct packed {
    logic up_ff;
    logic dn_ff;
    logic hold;
  } det_state_t;

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pfd_edge_divider.sv
module pfd_edge_divider #(
  parameter int unsigned RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               event_o
);

  localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] eff_ratio;
  logic               term;
  logic               event_d;
  logic               event_q;

  always_comb begin
    eff_ratio = (ratio_i < MIN_RATIO) ? MIN_RATIO : ratio_i;
    term      = (cnt_q == '0);
    cnt_d     = cnt_q;
    event_d   = 1'b0;
    if (tick_i) begin
      event_d = term;
      cnt_d   = term ? (eff_ratio - RATIO_W'(1)) : (cnt_q - RATIO_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      event_q <= 1'b0;
    end else begin
      event_q <= event_d;
      if (tick_i) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign event_o = event_q;

  // R1
  event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);

  // R1
  event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(tick_i));

endmodule

// File: rtl/pfd_detector.sv
module pfd_detector
  import pfd_front_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up_o,
  output logic dn_o
);

  det_state_t st_q, st_d;
  logic       both_set;

  always_comb begin
    both_set   = st_q.up_ff & st_q.dn_ff;
    st_d.up_ff = (st_q.up_ff & ~both_set) | ref_ev;
    st_d.dn_ff = (st_q.dn_ff & ~both_set) | fb_ev;
    st_d.hold  = ((st_q.up_ff | st_q.dn_ff) & st_q.hold) | both_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign up_o = st_q.up_ff & ~st_q.dn_ff & ~st_q.hold;
  assign dn_o = st_q.dn_ff & ~st_q.up_ff & ~st_q.hold;

  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.up_ff && st_q.dn_ff) |=> st_q.hold);

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.hold && (st_q.up_ff || st_q.dn_ff)) |=> st_q.hold);

  // R8
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.hold |-> (!up_o && !dn_o));

  // R7
  pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  // R4
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_o) |-> $past(ref_ev));

  // R5
  dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_o) |-> $past(fb_ev));

endmodule

// File: rtl/pfd_front.sv
module pfd_front
  import pfd_front_pkg::*;
#(
  parameter int unsigned RATIO_W     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               fb_tick,
  input  logic [RATIO_W-1:0] ref_ratio,
  input  logic [RATIO_W-1:0] fb_ratio,
  output logic               pump_up,
  output logic               pump_dn
);

  logic               rst_n_int;
  logic [NUM_CH-1:0]  tick_v;
  logic [NUM_CH-1:0]  ev_v;
  logic [RATIO_W-1:0] ratio_v [NUM_CH];

  assign tick_v[CH_REF]  = ref_tick;
  assign tick_v[CH_FB]   = fb_tick;
  assign ratio_v[CH_REF] = ref_ratio;
  assign ratio_v[CH_FB]  = fb_ratio;

  pfd_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_div
    pfd_edge_divider #(
      .RATIO_W (RATIO_W)
    ) u_div (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .tick_i  (tick_v[ch]),
      .ratio_i (ratio_v[ch]),
      .event_o (ev_v[ch])
    );
  end

  pfd_detector u_det (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .ref_ev (ev_v[CH_REF]),
    .fb_ev  (ev_v[CH_FB]),
    .up_o   (pump_up),
    .dn_o   (pump_dn)
  );

endmodule

// File: tb/sim_pfd_front.sv
module sim_pfd_front;

  localparam int RW = 12;

  logic          clk;
  logic          rst_n;
  logic          ref_tick;
  logic          fb_tick;
  logic [RW-1:0] ref_ratio;
  logic [RW-1:0] fb_ratio;
  logic          pump_up;
  logic          pump_dn;

  int n_chk;
  int n_err;
  bit done;

  pfd_front #(.RATIO_W(RW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .fb_tick   (fb_tick),
    .ref_ratio (ref_ratio),
    .fb_ratio  (fb_ratio),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    ref_tick = 1'b0;
    fb_tick  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // strobes every per cycles at the given phases; optional ref ratio rewrite
  task automatic run_pattern(input int n_act, input int per, input int ph_r,
                             input int ph_f, input int chg_cyc, input int chg_val,
                             output int up_c, output int dn_c, output int both_c);
    up_c = 0; dn_c = 0; both_c = 0;
    for (int c = 0; c < n_act + 12; c++) begin
      @(negedge clk);
      up_c   += int'(pump_up);
      dn_c   += int'(pump_dn);
      both_c += int'(pump_up & pump_dn);
      if (c == chg_cyc) ref_ratio = RW'(chg_val);
      ref_tick = (c < n_act) && ((c % per) == ph_r);
      fb_tick  = (c < n_act) && ((c % per) == ph_f);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9 up after reset", int'(pump_up), 0);
    check("R9 dn after reset", int'(pump_dn), 0);
  endtask

  task automatic t_ref_leads();
    int u, d, b;
    do_reset();
    ref_ratio = RW'(5); fb_ratio = RW'(5);
    run_pattern(400, 4, 0, 3, -1, 0, u, d, b);
    check("R4 R1 up cycles ref lead", u, 60);
    check("R4 dn idle ref lead", d, 0);
    check("R7 overlap ref lead", b, 0);
  endtask

  task automatic t_fb_leads();
    int u, d, b;
    do_reset();
    ref_ratio = RW'(5); fb_ratio = RW'(5);
    run_pattern(400, 4, 2, 0, -1, 0, u, d, b);
    check("R5 dn cycles fb lead", d, 40);
    check("R5 up idle fb lead", u, 0);
    check("R7 overlap fb lead", b, 0);
  endtask

  task automatic t_coincident();
    int u, d, b;
    do_reset();
    ref_ratio = RW'(7); fb_ratio = RW'(7);
    run_pattern(400, 4, 1, 1, -1, 0, u, d, b);
    check("R6 up coincident", u, 0);
    check("R6 dn coincident", d, 0);
  endtask

  task automatic t_clamp();
    int u, d, b;
    do_reset();
    ref_ratio = RW'(0); fb_ratio = RW'(1);
    run_pattern(400, 4, 0, 1, -1, 0, u, d, b);
    check("R2 up cycles clamped ratios", u, 50);
    check("R2 dn clamped ratios", d, 0);
  endtask

  task automatic t_freq_offset();
    int u, d, b;
    do_reset();
    ref_ratio = RW'(4); fb_ratio = RW'(5);
    run_pattern(81, 4, 0, 0, -1, 0, u, d, b);
    check("R4 up cycles faster ref", u, 40);
    check("R4 dn faster ref", d, 0);
    check("R7 overlap faster ref", b, 0);
  endtask

  task automatic t_ratio_change();
    int u, d, b;
    do_reset();
    ref_ratio = RW'(4); fb_ratio = RW'(4);
    run_pattern(41, 4, 0, 0, 1, 6, u, d, b);
    check("R3 dn cycles after ratio rewrite", d, 8);
    check("R3 up after ratio rewrite", u, 0);
  endtask

  task automatic t_clear_race();
    int u, d;
    do_reset();
    ref_ratio = RW'(2); fb_ratio = RW'(2);
    u = 0; d = 0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      u += int'(pump_up);
      d += int'(pump_dn);
      ref_tick = (c <= 2);
      fb_tick  = (c == 1);
    end
    check("R8 up held during clear race", u, 1);
    check("R8 dn during clear race", d, 0);
    u = 0; d = 0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      u += int'(pump_up);
      d += int'(pump_dn);
      ref_tick = 1'b0;
      fb_tick  = (c <= 1);
    end
    check("R8 up after release", u, 0);
    check("R8 dn after release", d, 0);
  endtask

  task automatic t_async_reset();
    do_reset();
    ref_ratio = RW'(5); fb_ratio = RW'(5);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    @(negedge clk);
    check("R4 up raised before reset", int'(pump_up), 1);
    rst_n = 1'b0;
    #1;
    check("R9 up cleared without clock", int'(pump_up), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 up after release", int'(pump_up), 0);
    check("R9 dn after release", int'(pump_dn), 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; ref_tick = 1'b0; fb_tick = 1'b0;
    ref_ratio = RW'(2); fb_ratio = RW'(2);
    t_reset_state();
    t_ref_leads();
    t_fb_leads();
    t_coincident();
    t_clamp();
    t_freq_offset();
    t_ratio_change();
    t_clear_race();
    t_async_reset();
    done = 1'b1;
    finish_run();
  end

endmodule